// File: doc/BRIEF.md
# Cursor and Character Blink Timer

This block makes the slow on/off rhythm used to flash a text cursor and one chosen character cell on a character display. The rhythm, called the blink phase, has a lit half and a dark half. It comes from one of two places, chosen by a select pin. The first is an external 2 Hz tick. It is synchronised, its rising edges are detected, and it is then divided by two. The second is an internal prescaler counting system clocks. A clear pulse restarts both dividers and forces the phase into its lit half, so that several displays, or a time mark, can be brought into step.

A small command port sets three things: the cursor mode, the character-blink enable, and the single cell these attributes apply to. The cell is loaded in two steps. An X column write arms the load, and the Y row write that follows commits it. A query port asks, for any cell, whether the cursor is drawn and whether the character is drawn, and answers one cycle later. The command port takes one command in every cycle where `cmd_valid_i` is high. The query port takes one query in every cycle where `q_valid_i` is high. Neither port ever applies back-pressure, so there is no ready signal.

Top module: `blink_attr_timer`

## Requirements
- R1: With `src_int_i`=0, each rising edge of `ext_tick_i` inverts `phase_o`. The change appears on the third rising clock edge after the input rises. Falling edges of `ext_tick_i` have no effect.
- R2: With `src_int_i`=1, `phase_o` inverts once every PRESCALE clock cycles, counted from the last clear. In this mode, edges on `ext_tick_i` have no effect.
- R3: A cycle with `scaler_clr_i`=1 sets `phase_o` to 1 (lit) at the next clock edge and restarts the prescaler count from zero.
- R4: Command op 0 sets the cursor mode from `cmd_arg_i[1:0]`. The codes are: 0 hidden, 1 always shown, 2 shown when `phase_o`=1. Code 3 is ignored and the previous mode stays in force. The cursor is reported only for the stored cell.
- R5: Command op 1 sets the character-blink enable from `cmd_arg_i[0]`. Bit 1 is don't-care. When the enable is 1, the stored cell's character is shown only while `phase_o`=1. Every other cell, and every cell while the enable is 0, reports its character as shown.
- R6: Command op 2 (X write, value in `cmd_arg_i`) arms a position load. The next op 3 (Y write, value in `cmd_arg_i[2:0]`) commits the pair as the single attribute cell. If several X writes come before the Y write, the last one wins.
- R7: A Y write that has no armed X write before it is ignored. This includes a second Y write after a commit. The stored cell stays unchanged.
- R8: An X write above 21 (hex 15) is ignored and does not arm a load.
- R9: A query presented with `q_valid_i`=1 is answered on `cur_show_o` and `chr_show_o`, with `q_valid_o`=1, one clock cycle later. `q_valid_o` is 0 in the cycle after a cycle with no query.
- R10: After reset, `phase_o`=1, the cursor is hidden, character blink is off, the stored cell is (0,0) and no load is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick_i | input | 1 | Asynchronous 2 Hz blink tick |
| src_int_i | input | 1 | Blink source: 0 external tick, 1 internal prescaler |
| scaler_clr_i | input | 1 | Clear both dividers and force the lit phase |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 cursor mode, 1 blink enable, 2 X write, 3 Y write |
| cmd_arg_i | input | XW | Command argument |
| q_valid_i | input | 1 | Query present this cycle |
| q_x_i | input | XW | Queried column |
| q_y_i | input | YW | Queried row |
| q_valid_o | output | 1 | Query answer valid |
| cur_show_o | output | 1 | Cursor drawn at the queried cell |
| chr_show_o | output | 1 | Character drawn at the queried cell |
| phase_o | output | 1 | Blink phase, 1 = lit |

## Verification
The hardest states to reach are the ones where a partly written position meets the blink phase. Examples are a Y write with no X armed, an X write that was rejected, and a blinking cell queried during the dark half. Only the command sequence can reach these, and the phase only changes on slow edges. The bench drives the external tick by hand, so it can set the phase to either half at will. For each mode, blink and phase combination it then sweeps every column and row code. Separate command sequences leave the arming logic in each of its states before the query sweep confirms where the attribute landed.

// File: rtl/bat_pkg.sv
package bat_pkg;
  typedef enum logic [1:0] {
    OP_CURSOR = 2'd0,
    OP_BLINK  = 2'd1,
    OP_XWRITE = 2'd2,
    OP_YWRITE = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    CUR_HIDE   = 2'd0,
    CUR_STEADY = 2'd1,
    CUR_FLASH  = 2'd2,
    CUR_RSVD   = 2'd3
  } cur_mode_e;
endpackage

// File: rtl/bat_phase_gen.sv
module bat_phase_gen #(
  parameter int PRESCALE = 62_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick_i,
  input  logic src_int_i,
  input  logic clr_i,
  output logic phase_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [2:0]    sync_q;   // [0],[1] synchroniser, [2] previous value
  logic          rise;
  logic [CW-1:0] cnt_q;
  logic          term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_tick_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];
  assign term = (cnt_q == CW'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (term)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          phase_o <= 1'b1;
    else if (clr_i)                      phase_o <= 1'b1;
    else if (src_int_i ? term : rise)    phase_o <= ~phase_o;
  end

  // R1: a detected external edge flips the phase in the external mode
  a_r1_ext_edge_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_int_i && rise && !clr_i) |=> (phase_o != $past(phase_o)));
  // R2: between terminal counts the internal phase holds
  a_r2_int_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (src_int_i && !term && !clr_i) |=> $stable(phase_o));
  // R3: a clear lands in the lit phase
  a_r3_clear_lit: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> phase_o);
endmodule

// File: rtl/bat_cell_reg.sv
module bat_cell_reg
  import bat_pkg::*;
#(
  parameter int XW   = 5,
  parameter int YW   = 3,
  parameter int XMAX = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [XW-1:0] cmd_arg_i,
  output cur_mode_e     cur_mode_o,
  output logic          blink_en_o,
  output logic [XW-1:0] pos_x_o,
  output logic [YW-1:0] pos_y_o
);
  cmd_op_e       op;
  logic          armed_q;
  logic [XW-1:0] x_pend_q;
  logic          x_ok;

  assign op   = cmd_op_e'(cmd_op_i);
  assign x_ok = (cmd_arg_i <= XW'(XMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode_o <= CUR_HIDE;
      blink_en_o <= 1'b0;
      pos_x_o    <= '0;
      pos_y_o    <= '0;
      armed_q    <= 1'b0;
      x_pend_q   <= '0;
    end else if (cmd_valid_i) begin
      unique case (op)
        OP_CURSOR: if (cmd_arg_i[1:0] != CUR_RSVD) cur_mode_o <= cur_mode_e'(cmd_arg_i[1:0]);
        OP_BLINK:  blink_en_o <= cmd_arg_i[0];
        OP_XWRITE: if (x_ok) begin
          x_pend_q <= cmd_arg_i;
          armed_q  <= 1'b1;
        end
        OP_YWRITE: if (armed_q) begin
          pos_x_o <= x_pend_q;
          pos_y_o <= cmd_arg_i[YW-1:0];
          armed_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R4: the reserved cursor code leaves the mode alone
  a_r4_rsvd_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && op == OP_CURSOR && cmd_arg_i[1:0] == 2'b11) |=> $stable(cur_mode_o));
  // R6: a committing Y write consumes the arming
  a_r6_commit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && op == OP_YWRITE && armed_q) |=> !armed_q);
  // R7: an unarmed Y write does not move the cell
  a_r7_lone_y_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && op == OP_YWRITE && !armed_q) |=> ($stable(pos_x_o) && $stable(pos_y_o)));
  // R8: an out-of-range X write changes neither arming nor the pending column
  a_r8_bad_x_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && op == OP_XWRITE && !x_ok) |=> ($stable(armed_q) && $stable(x_pend_q)));
endmodule

// File: rtl/bat_query.sv
module bat_query
  import bat_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid_i,
  input  logic [XW-1:0] q_x_i,
  input  logic [YW-1:0] q_y_i,
  input  cur_mode_e     cur_mode_i,
  input  logic          blink_en_i,
  input  logic [XW-1:0] pos_x_i,
  input  logic [YW-1:0] pos_y_i,
  input  logic          phase_i,
  output logic          q_valid_o,
  output logic          cur_show_o,
  output logic          chr_show_o
);
  logic hit;
  logic cur_d;
  logic chr_d;

  assign hit = (q_x_i == pos_x_i) && (q_y_i == pos_y_i);

  always_comb begin
    cur_d = 1'b0;
    if (hit) begin
      case (cur_mode_i)
        CUR_STEADY: cur_d = 1'b1;
        CUR_FLASH:  cur_d = phase_i;
        default:    cur_d = 1'b0;
      endcase
    end
    chr_d = (hit && blink_en_i) ? phase_i : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid_o  <= 1'b0;
      cur_show_o <= 1'b0;
      chr_show_o <= 1'b1;
    end else begin
      q_valid_o <= q_valid_i;
      if (q_valid_i) begin
        cur_show_o <= cur_d;
        chr_show_o <= chr_d;
      end
    end
  end

  // R9: every query is answered on the following cycle
  a_r9_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid_i |=> q_valid_o);
  // R4: a hidden cursor is never reported
  a_r4_hidden_cursor: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid_i && cur_mode_i == CUR_HIDE) |=> !cur_show_o);
  // R5: with blink off every character is drawn
  a_r5_no_blink_drawn: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid_i && !blink_en_i) |=> chr_show_o);
endmodule

// File: rtl/blink_attr_timer.sv
module blink_attr_timer
  import bat_pkg::*;
#(
  parameter int PRESCALE = 62_500_000,
  parameter int XW       = 5,
  parameter int YW       = 3,
  parameter int XMAX     = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_tick_i,
  input  logic          src_int_i,
  input  logic          scaler_clr_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [XW-1:0] cmd_arg_i,
  input  logic          q_valid_i,
  input  logic [XW-1:0] q_x_i,
  input  logic [YW-1:0] q_y_i,
  output logic          q_valid_o,
  output logic          cur_show_o,
  output logic          chr_show_o,
  output logic          phase_o
);
  cur_mode_e     cur_mode;
  logic          blink_en;
  logic [XW-1:0] pos_x;
  logic [YW-1:0] pos_y;

  bat_phase_gen #(.PRESCALE(PRESCALE)) u_phase (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick_i),
    .src_int_i(src_int_i), .clr_i(scaler_clr_i), .phase_o(phase_o)
  );

  bat_cell_reg #(.XW(XW), .YW(YW), .XMAX(XMAX)) u_cell (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_arg_i(cmd_arg_i), .cur_mode_o(cur_mode), .blink_en_o(blink_en),
    .pos_x_o(pos_x), .pos_y_o(pos_y)
  );

  bat_query #(.XW(XW), .YW(YW)) u_query (
    .clk(clk), .rst_n(rst_n), .q_valid_i(q_valid_i), .q_x_i(q_x_i), .q_y_i(q_y_i),
    .cur_mode_i(cur_mode), .blink_en_i(blink_en), .pos_x_i(pos_x), .pos_y_i(pos_y),
    .phase_i(phase_o), .q_valid_o(q_valid_o), .cur_show_o(cur_show_o),
    .chr_show_o(chr_show_o)
  );
endmodule

// File: tb/sim_blink_attr_timer.sv
module sim_blink_attr_timer;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_tick = 1'b0, src_int = 1'b0, clr = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [4:0] cmd_arg = '0;
  logic       q_valid = 1'b0;
  logic [4:0] q_x = '0;
  logic [2:0] q_y = '0;
  logic       q_valid_o, cur_show, chr_show, phase;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  // bench model
  int  m_mode = 0, m_blink = 0, m_px = 0, m_py = 0;
  logic m_phase = 1'b1;

  always #4 clk = ~clk;

  blink_attr_timer #(.PRESCALE(P)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick), .src_int_i(src_int),
    .scaler_clr_i(clr), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_arg_i(cmd_arg),
    .q_valid_i(q_valid), .q_x_i(q_x), .q_y_i(q_y), .q_valid_o(q_valid_o),
    .cur_show_o(cur_show), .chr_show_o(chr_show), .phase_o(phase)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cmd(input int op, input int arg);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_arg = 5'(arg);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic query(input int x, input int y);
    logic hit, ec, eh;
    q_valid = 1'b1; q_x = 5'(x); q_y = 3'(y);
    tick();
    q_valid = 1'b0;
    hit = (x == m_px) && (y == m_py);
    ec  = hit && ((m_mode == 1) || (m_mode == 2 && m_phase));
    eh  = (hit && m_blink == 1) ? m_phase : 1'b1;
    check(q_valid_o, 1'b1, "R9");
    check(cur_show, ec, "R4");
    check(chr_show, eh, "R5");
  endtask

  task automatic ext_pulse();  // R1: flip phase via the external tick
    ext_tick = 1'b1; repeat (4) tick();
    m_phase = ~m_phase;
    check(phase, m_phase, "R1 rising edge");
    ext_tick = 1'b0; repeat (4) tick();
    check(phase, m_phase, "R1 falling edge");
  endtask

  task automatic clear_lit();
    clr = 1'b1; tick(); clr = 1'b0;
    m_phase = 1'b1;
    check(phase, 1'b1, "R3 clear lit");
  endtask

  task automatic int_sweep(input int len);  // R2: starts right after a clear
    for (int n = 1; n <= len; n++) begin
      if (n % 5 == 0) ext_tick = ~ext_tick;
      tick();
      check(phase, ((n / P) % 2) == 0, "R2 internal phase");
    end
    m_phase = phase;
  endtask

  initial begin
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    check(phase, 1'b1, "R10 phase lit");
    check(q_valid_o, 1'b0, "R10 no answer");
    query(0, 0);   // R10 hidden cursor, blink off at (0,0)

    for (int i = 0; i < 6; i++) ext_pulse();

    src_int = 1'b1;
    clear_lit();
    int_sweep(3 * P);
    check(phase, 1'b0, "R2 dark before clear");
    clear_lit();
    int_sweep(2 * P);
    src_int = 1'b0; ext_tick = 1'b0;
    repeat (4) tick();
    clear_lit();

    cmd(2, 5); cmd(3, 3); m_px = 5; m_py = 3;   // R6
    for (int md = 0; md < 4; md++) begin
      cmd(0, md);
      if (md != 3) m_mode = md;                 // R4 code 3 ignored
      for (int b = 0; b < 2; b++) begin
        cmd(1, 2 | b); m_blink = b;             // R5 bit 1 don't-care
        for (int ph = 0; ph < 2; ph++) begin
          for (int x = 0; x < 32; x++)
            for (int y = 0; y < 8; y++) query(x, y);
          ext_pulse();
        end
      end
    end

    cmd(0, 1); m_mode = 1; cmd(1, 0); m_blink = 0;
    cmd(3, 6);                                  // R7 lone Y after commit
    query(5, 3); query(5, 6);
    cmd(2, 21); cmd(3, 7); m_px = 21; m_py = 7; // R6 boundary
    query(21, 7); query(20, 7);
    cmd(2, 22); cmd(3, 0);                      // R8 rejected X, Y then unarmed
    query(21, 7); query(22, 0); query(21, 0);
    cmd(2, 2); cmd(2, 9); cmd(3, 1); m_px = 9; m_py = 1;  // R6 last X wins
    query(9, 1); query(2, 1);
    tick();
    check(q_valid_o, 1'b0, "R9 idle");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule